// File: doc/BRIEF.md
# Partitionable Unsigned Multiplier

This block multiplies two 36-bit unsigned operands into a 72-bit result. A static partition select can also split the datapath into narrower, independent multipliers. The split always falls on fixed halves of the ports, so it yields one 36x36 product, two 18x18 products or four 9x9 products. Each narrow product lands in its own slice of the result and never carries into a neighbouring slice.

Three pipeline stages surround the arithmetic: a register on operand A, a register on operand B, and a register on the full product. Each stage has its own bypass select. Taking the stored value or the live value sets the latency to zero, one or two cycles. All stages share one clock, one synchronous active-high reset and one clock enable. The partition and bypass selects are set up before use and are not changed during operation.

Top module: `fmul_frac`

## Requirements
- R1: With `mode` = 2'b00, `y` equals the full unsigned 72-bit product `a * b`.
- R2: `mode` = 2'b11 gives exactly the same result as 2'b00.
- R3: With `mode` = 2'b01, `y[35:0] = a[17:0]*b[17:0]` and `y[71:36] = a[35:18]*b[35:18]`.
- R4: With `mode` = 2'b10, for k = 0..3, `y[18k+17:18k] = a[9k+8:9k]*b[9k+8:9k]`.
- R5: In the split partitions, each product stays inside its own slice. All-ones operands produce no carry into the next slice.
- R6: With `byp_a`, `byp_b` and `byp_o` all 1, `y` follows the inputs in the same cycle, with no clock edge needed.
- R7: With the input stages in use (`byp_a` = `byp_b` = 0) and `byp_o` = 1, the product of the inputs appears one clock edge after they are applied.
- R8: With `byp_o` = 0 and the input stages bypassed, `y` changes only at a clock edge. It shows the product of the inputs present at that edge.
- R9: With all three stages in use, the latency is two clock edges.
- R10: A clock edge with `rst` = 1 clears every stage. The clear takes priority over `ce`, and a fully registered `y` then reads 0.
- R11: While `ce` = 0, every stage keeps its contents, and a registered `y` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| rst | input | 1 | Synchronous active-high clear |
| ce | input | 1 | Clock enable for all stages |
| mode | input | 2 | Partition: 00 one 36x36, 01 two 18x18, 10 four 9x9, 11 same as 00 |
| byp_a | input | 1 | 1 = operand A stage bypassed |
| byp_b | input | 1 | 1 = operand B stage bypassed |
| byp_o | input | 1 | 1 = product stage bypassed |
| a | input | 36 | Operand A |
| b | input | 36 | Operand B |
| y | output | 72 | Result, one product or sliced products |

## Verification
Two classes of internal fault show up at the result port.

A partial product gated in the wrong partition corrupts whole result slices. It is visible in the same cycle when every stage is bypassed. The all-ones vectors make any carry that leaks across a slice boundary land in the lowest bit of the next slice.

A register that ignores the enable, misses the clear or is wired around its bypass shows up one or two edges later. `y` then holds the wrong value, or changes on a cycle where it should not.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        PART_WIDE    = 2'b00,
        PART_HALF    = 2'b01,
        PART_QUARTER = 2'b10,
        PART_WIDE_X  = 2'b11
    } part_e;

    typedef struct packed {
        logic skip_a;
        logic skip_b;
        logic skip_o;
    } stage_cfg_t;

    // Does partial product (i,j) contribute in the given partition?
    function automatic logic pp_used(part_e p, int i, int j);
        case (p)
            PART_HALF:    return (i / 2) == (j / 2);
            PART_QUARTER: return i == j;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fmul_stage.sv
module fmul_stage #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         skip,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)     held <= '0;
        else if (ce) held <= d;
    end

    assign q = skip ? d : held;
endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
#(
    parameter int OPW = 36
) (
    input  part_e              part,
    input  logic [OPW-1:0]     x,
    input  logic [OPW-1:0]     z,
    output logic [2*OPW-1:0]   p
);
    localparam int LW = OPW / LANES;

    logic [2*LW-1:0] pp [LANES][LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_row
        for (genvar j = 0; j < LANES; j++) begin : g_col
            assign pp[i][j] = x[LW*i +: LW] * z[LW*j +: LW];
        end
    end

    // The weight of (i,j) is LW*(i+j) in every partition; the partition
    // only decides which partial products take part.
    always_comb begin
        p = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (pp_used(part, i, j))
                    p = p + ((2*OPW)'(pp[i][j]) << (LW * (i + j)));
            end
        end
    end
endmodule

// File: rtl/fmul_frac.sv
module fmul_frac
    import fmul_pkg::*;
#(
    parameter int OPW = 36
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic [1:0]         mode,
    input  logic               byp_a,
    input  logic               byp_b,
    input  logic               byp_o,
    input  logic [OPW-1:0]     a,
    input  logic [OPW-1:0]     b,
    output logic [2*OPW-1:0]   y
);
    localparam int PW = 2 * OPW;

    stage_cfg_t       cfg;
    part_e            part;
    logic [OPW-1:0]   a_s, b_s;
    logic [PW-1:0]    prod;

    assign cfg  = '{skip_a: byp_a, skip_b: byp_b, skip_o: byp_o};
    assign part = part_e'(mode);

    fmul_stage #(.W(OPW)) u_sa (.clk(clk), .rst(rst), .ce(ce), .skip(cfg.skip_a), .d(a), .q(a_s));
    fmul_stage #(.W(OPW)) u_sb (.clk(clk), .rst(rst), .ce(ce), .skip(cfg.skip_b), .d(b), .q(b_s));

    fmul_core #(.OPW(OPW)) u_core (.part(part), .x(a_s), .z(b_s), .p(prod));

    fmul_stage #(.W(PW)) u_so (.clk(clk), .rst(rst), .ce(ce), .skip(cfg.skip_o), .d(prod), .q(y));
endmodule

// File: rtl/fmul_frac_chk.sv
module fmul_frac_chk #(
    parameter int OPW = 36
) (
    input logic               clk,
    input logic               rst,
    input logic               ce,
    input logic [1:0]         mode,
    input logic               byp_a,
    input logic               byp_b,
    input logic               byp_o,
    input logic [OPW-1:0]     a,
    input logic [OPW-1:0]     b,
    input logic [2*OPW-1:0]   y
);
    localparam int PW = 2 * OPW;
    localparam int LW = OPW / 4;

    logic all_skip;
    assign all_skip = byp_a && byp_b && byp_o;

    assert_wide_product_R1: assert property (@(posedge clk) disable iff (rst)
        (all_skip && mode == 2'b00) |-> (y == PW'(a) * PW'(b)));

    assert_lane_isolated_R5: assert property (@(posedge clk) disable iff (rst)
        (all_skip && mode == 2'b10) |->
        (y[PW-1 -: 2*LW] == (2*LW)'(a[OPW-1 -: LW]) * (2*LW)'(b[OPW-1 -: LW])));

    assert_out_stage_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (byp_a && byp_b && !byp_o && ce && mode == 2'b00) |=>
        (byp_o || y == $past(PW'(a) * PW'(b))));

    assert_clear_out_R10: assert property (@(posedge clk)
        (rst && !byp_o) |=> (byp_o || y == '0));

    assert_hold_on_disable_R11: assert property (@(posedge clk) disable iff (rst)
        (!ce && !byp_o) |=> (byp_o || $stable(y)));
endmodule

bind fmul_frac fmul_frac_chk #(.OPW(OPW)) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode), .byp_a(byp_a), .byp_b(byp_b),
    .byp_o(byp_o), .a(a), .b(b), .y(y)
);

// File: tb/fmul_frac_test.sv
module fmul_frac_test;
    localparam int OPW = 36;
    localparam int PW  = 72;
    localparam int NV  = 10;

    logic clk = 1'b0;
    logic rst, ce, byp_a, byp_b, byp_o;
    logic [1:0]     mode;
    logic [OPW-1:0] a, b;
    logic [PW-1:0]  y;

    int errs = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    fmul_frac #(.OPW(OPW)) uut (
        .clk(clk), .rst(rst), .ce(ce), .mode(mode), .byp_a(byp_a), .byp_b(byp_b),
        .byp_o(byp_o), .a(a), .b(b), .y(y)
    );

    // {mode, a, b}
    localparam logic [73:0] VEC [NV] = '{
        {2'b00, 36'h0_0000_0003, 36'h0_0000_0005},
        {2'b00, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF},
        {2'b00, 36'h1_2345_6789, 36'hA_BCDE_F012},
        {2'b11, 36'h1_2345_6789, 36'hA_BCDE_F012},
        {2'b11, 36'hF_FFFF_FFFF, 36'h8_0000_0001},
        {2'b01, 36'h1_2345_6789, 36'hA_BCDE_F012},
        {2'b01, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF},
        {2'b10, 36'h1_2345_6789, 36'hA_BCDE_F012},
        {2'b10, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF},
        {2'b10, 36'h0_3FE0_0201, 36'h8_01FF_C0FF}
    };

    function automatic logic [PW-1:0] model(logic [1:0] m, logic [OPW-1:0] x, logic [OPW-1:0] z);
        logic [PW-1:0] r;
        r = '0;
        case (m)
            2'b01: begin
                r[35:0]  = 36'(x[17:0])  * 36'(z[17:0]);
                r[71:36] = 36'(x[35:18]) * 36'(z[35:18]);
            end
            2'b10: begin
                for (int k = 0; k < 4; k++)
                    r[18*k +: 18] = 18'(x[9*k +: 9]) * 18'(z[9*k +: 9]);
            end
            default: r = PW'(x) * PW'(z);
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [PW-1:0] exp);
        checks++;
        if (y !== exp) begin
            errs++;
            $display("FAIL %s: y=%h expected %h", req, y, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] e1, e2;
        rst = 1'b1; ce = 1'b1; mode = 2'b00;
        byp_a = 1'b0; byp_b = 1'b0; byp_o = 1'b0;
        a = 36'h1_2345_6789; b = 36'h5_5555_5555;
        step(); step();
        check("R10 reset clears", '0);
        // Clear wins over a low enable; inputs held while disabled
        ce = 1'b0;
        step();
        rst = 1'b0;
        step(); step();
        check("R10/R11 cleared stages held", '0);
        ce = 1'b1;

        // Combinational table: R1 R2 R3 R4 R5 R6
        byp_a = 1'b1; byp_b = 1'b1; byp_o = 1'b1;
        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][73:72];
            a = VEC[i][71:36];
            b = VEC[i][35:0];
            #0.5;
            case (mode)
                2'b00:   check("R1/R6 wide", model(mode, a, b));
                2'b11:   check("R2 alias of wide", model(2'b00, a, b));
                2'b01:   check("R3/R5 halves", model(mode, a, b));
                default: check("R4/R5 quarters", model(mode, a, b));
            endcase
        end
        // Explicit no-carry check: quarter all ones
        mode = 2'b10; a = '1; b = '1; #0.5;
        check("R5 no carry", {4{18'h3FC01}});

        // R7 input stages only
        mode = 2'b00; byp_a = 1'b0; byp_b = 1'b0; byp_o = 1'b1;
        a = 36'h0_0001_0001; b = 36'h0_0000_0007;
        step();
        e1 = model(2'b00, a, b);
        a = 36'h3_0000_0002; b = 36'h0_0000_0100; #0.5;
        check("R7 holds before edge", e1);
        step();
        check("R7 one edge", model(2'b00, a, b));

        // R8 output stage only
        mode = 2'b01; byp_a = 1'b1; byp_b = 1'b1; byp_o = 1'b0;
        a = 36'h2_0003_0004; b = 36'h1_0002_0005;
        step();
        e1 = model(2'b01, a, b);
        check("R8 one edge", e1);
        a = 36'h0_0010_0020; #0.5;
        check("R8 stable between edges", e1);
        step();
        check("R8 next edge", model(2'b01, a, b));

        // R9 all stages
        mode = 2'b10; byp_a = 1'b0; byp_b = 1'b0; byp_o = 1'b0;
        a = 36'h1_2345_6789; b = 36'hA_BCDE_F012;
        e1 = model(2'b10, a, b);
        step();
        a = '1; b = '1;
        e2 = model(2'b10, a, b);
        step();
        check("R9 two edges first", e1);
        step();
        check("R9 two edges second", e2);

        // R11 hold with enable low
        ce = 1'b0;
        a = 36'h0_0000_0011; b = 36'h0_0000_0013;
        step(); step(); step();
        check("R11 held", e2);
        ce = 1'b1;
        step(); step();
        check("R11 resumes", model(2'b10, a, b));

        // R10 mid-run clear
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R10 mid-run clear", '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule